// File: doc/BRIEF.md
# Programmable handshake bus cycle generator

This block runs one external memory read or write cycle at a time. Every edge of the cycle comes from a 16-bit timing word:
- when the address window closes;
- when the read or write strobe rises and falls;
- when the external acknowledge is first sampled;
- when the cycle ends.

A start strobe launches the cycle. The block captures the timing word and the read/write select on that clock. A cycle counter then advances once per master clock. While the counter sits at the acknowledge sampling count and the acknowledge input is low, the counter stalls. The strobe and address outputs hold their values during the stall.

The timing word is honoured only in handshake mode, which is a DRAM-select input at 0 and a handshake-select input at 1. In any other mode a start request is dropped. Some timing words are illegal. An illegal word refuses the start and produces a one-clock error pulse in place of the done pulse. All pins are plain control and status signals. The block has no data stream, so no valid/ready back-pressure applies.

Top module: `hsbus_cycle_gen`

## Requirements
- R1: A start is accepted only when the block is idle, `sel_dram`=0, `sel_hs`=1 and the word is legal. `busy` rises on the clock after the accepted start. In any other mode the start is dropped: `busy` and `cfg_err` stay low.
- R2: A word is illegal when any of these holds:
  - `cfg_word[1:0]`=00;
  - `cfg_word[3:2]`=00;
  - `cfg_word[10:6]` < `cfg_word[15:11]`.

  An illegal word in handshake mode refuses the start. `cfg_err` is then high for exactly the next clock and `busy` stays low.
- R3: The cycle count is 0 on the first busy clock. It rises by one on each following clock unless stalled (R6).
- R4: `addr_en` is high while busy and the count is below `cfg_word[5:4]`. A value of 0 gives no address window.
- R5: The strobe is high while busy and `cfg_word[3:2]` ≤ count < `cfg_word[15:11]`. The strobe is `rd_en` when `is_write`=0 and `wr_en` when `is_write`=1. The other strobe stays low.
- R6: While the count equals `cfg_word[1:0]` and `ack` is low, the count holds and all outputs hold. Counting resumes on the clock after `ack` is seen high at that count.
- R7: When the count equals `cfg_word[10:6]` and the cycle is not stalled, `done` is high for exactly the next clock and `busy` falls on that same clock.
- R8: The word and `is_write` are captured at the accepted start. Changing them during the cycle has no effect on that cycle.
- R9: A start raised while busy is ignored. It does not restart or extend the cycle.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Cycle request strobe |
| is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| sel_dram | input | 1 | DRAM mode select; must be 0 |
| sel_hs | input | 1 | Handshake mode select; must be 1 |
| cfg_word | input | 16 | Timing configuration word |
| ack | input | 1 | External acknowledge |
| addr_en | output | 1 | Address-valid window |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| cfg_err | output | 1 | One-clock illegal-setting pulse |

## Verification
The bench aims at the following corner cases:

- **Zero end time.** A design that counted before testing for the end would run one clock too long.
- **Equal end and negate times.** A design with an off-by-one in the strobe window would miss the last strobe clock or add an extra one.
- **Long acknowledge stalls at each sampling count.** A design that did not hold its count would drop the strobe early.
- **Sampling point after the cycle end.** Here the acknowledge must be ignored.
- **Each of the three illegal-word forms.** A wrong decoder would launch a cycle or leave `cfg_err` silent.
- **Mid-cycle changes to the word and the select, and a start raised while busy.** These expose a design that reads live inputs instead of its captured copy.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  parameter int unsigned SHORT_W = 2;
  parameter int unsigned LONG_W  = 5;
  localparam int unsigned CFG_W  = 3 * SHORT_W + 2 * LONG_W;

  // Field order follows the bit layout of the timing word, MSB first
  typedef struct packed {
    logic [LONG_W-1:0]  neg_t;   // strobe negate count
    logic [LONG_W-1:0]  end_t;   // cycle end count
    logic [SHORT_W-1:0] adr_t;   // address window end count
    logic [SHORT_W-1:0] asr_t;   // strobe assert count
    logic [SHORT_W-1:0] smp_t;   // acknowledge sampling count
  } hsb_timing_t;

  function automatic logic [LONG_W-1:0] widen(input logic [SHORT_W-1:0] v);
    return {{(LONG_W - SHORT_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/hsb_field_decode.sv
module hsb_field_decode
  import hsb_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output hsb_timing_t      tm,
  output logic             legal
);
  always_comb begin
    tm    = hsb_timing_t'(cfg_word);
    legal = (tm.smp_t != '0) && (tm.asr_t != '0) && (tm.end_t >= tm.neg_t);
  end
endmodule

// File: rtl/hsb_seq_counter.sv
module hsb_seq_counter
  import hsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  hsb_timing_t       tm_in,
  input  logic              wr_in,
  input  logic              ack,
  output logic              active,
  output logic [LONG_W-1:0] cnt,
  output hsb_timing_t       tm_q,
  output logic              wr_q,
  output logic              done
);
  logic stall, at_end;

  always_comb begin
    stall  = active && (cnt == widen(tm_q.smp_t)) && !ack;
    at_end = active && (cnt == tm_q.end_t);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tm_q   <= '0;
      wr_q   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (launch) begin
          active <= 1'b1;
          cnt    <= '0;
          tm_q   <= tm_in;
          wr_q   <= wr_in;
        end
      end else if (stall) begin
        cnt <= cnt;
      end else if (at_end) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> active && $stable(cnt));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !stall && !at_end) |=> active && ((cnt - $past(cnt)) == 1));
endmodule

// File: rtl/hsb_strobe_gen.sv
module hsb_strobe_gen
  import hsb_pkg::*;
(
  input  logic              active,
  input  logic [LONG_W-1:0] cnt,
  input  hsb_timing_t       tm_q,
  input  logic              wr_q,
  output logic              addr_en,
  output logic              rd_en,
  output logic              wr_en
);
  logic strobe;

  always_comb begin
    addr_en = active && (cnt < widen(tm_q.adr_t));
    strobe  = active && (cnt >= widen(tm_q.asr_t)) && (cnt < tm_q.neg_t);
    rd_en   = strobe && !wr_q;
    wr_en   = strobe && wr_q;
  end
endmodule

// File: rtl/hsbus_cycle_gen.sv
module hsbus_cycle_gen
  import hsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             sel_dram,
  input  logic             sel_hs,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ack,
  output logic             addr_en,
  output logic             rd_en,
  output logic             wr_en,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  hsb_timing_t       tm_live, tm_q;
  logic              legal, active, wr_q, req, launch;
  logic [LONG_W-1:0] cnt;

  hsb_field_decode u_dec (
    .cfg_word (cfg_word),
    .tm       (tm_live),
    .legal    (legal)
  );

  always_comb begin
    req    = start && !sel_dram && sel_hs && !active;
    launch = req && legal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= req && !legal;
  end

  hsb_seq_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .tm_in  (tm_live),
    .wr_in  (is_write),
    .ack    (ack),
    .active (active),
    .cnt    (cnt),
    .tm_q   (tm_q),
    .wr_q   (wr_q),
    .done   (done)
  );

  hsb_strobe_gen u_stb (
    .active  (active),
    .cnt     (cnt),
    .tm_q    (tm_q),
    .wr_q    (wr_q),
    .addr_en (addr_en),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  assign busy = active;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  // R7
  done_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R2
  err_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !done && !$past(busy));
endmodule

// File: tb/hsbus_cycle_gen_test.sv
module hsbus_cycle_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_write = 1'b0, sel_dram = 1'b0, sel_hs = 1'b1, ack = 1'b1;
  logic [15:0] cfg_word = 16'h0;
  logic addr_en, rd_en, wr_en, busy, done, cfg_err;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R3";

  // reference model state
  bit m_act, m_wr, m_done, m_err;
  int m_cnt;
  logic [15:0] m_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsbus_cycle_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .sel_dram(sel_dram), .sel_hs(sel_hs), .cfg_word(cfg_word), .ack(ack),
    .addr_en(addr_en), .rd_en(rd_en), .wr_en(wr_en), .busy(busy),
    .done(done), .cfg_err(cfg_err)
  );

  function automatic bit cfg_legal(logic [15:0] c);
    return (c[1:0] != 2'b00) && (c[3:2] != 2'b00) && (c[10:6] >= c[15:11]);
  endfunction

  function automatic logic [15:0] mk_cfg(int smp, int asr, int adr, int endt, int negt);
    return {5'(negt), 5'(endt), 2'(adr), 2'(asr), 2'(smp)};
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_done = 0; m_err = 0; m_wr = 0; m_cfg = '0;
    end else if (!m_act) begin
      m_done = 0; m_err = 0;
      if (start && !sel_dram && sel_hs) begin
        if (cfg_legal(cfg_word)) begin
          m_act = 1; m_cnt = 0; m_cfg = cfg_word; m_wr = is_write;
        end else m_err = 1;
      end
    end else begin
      m_done = 0; m_err = 0;
      if (m_cnt == int'(m_cfg[1:0]) && !ack) ;
      else if (m_cnt == int'(m_cfg[10:6])) begin m_act = 0; m_done = 1; end
      else m_cnt++;
    end
  endtask

  task automatic compare();
    bit stb;
    stb = m_act && (m_cnt >= int'(m_cfg[3:2])) && (m_cnt < int'(m_cfg[15:11]));
    chk(cur_tag, "busy", busy, m_act);
    chk("R4", "addr_en", addr_en, m_act && (m_cnt < int'(m_cfg[5:4])));
    chk("R5", "rd_en", rd_en, stb && !m_wr);
    chk("R5", "wr_en", wr_en, stb && m_wr);
    chk("R7", "done", done, m_done);
    chk("R2", "cfg_err", cfg_err, m_err);
  endtask

  // called at a negedge with inputs already set
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_in(bit s, bit w, logic [15:0] c, bit a);
    start = s; is_write = w; cfg_word = c; ack = a;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) begin
      set_in(0, is_write, cfg_word, 1);
      step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R10: reset holds outputs low
    @(negedge clk);
    model_edge();
    step();
    cur_tag = "R10";
    chk("R10", "busy", busy, 0); chk("R10", "addr_en", addr_en, 0);
    chk("R10", "rd_en", rd_en, 0); chk("R10", "wr_en", wr_en, 0);
    chk("R10", "done", done, 0); chk("R10", "cfg_err", cfg_err, 0);
    rst_n = 1'b1;

    // R1: wrong mode drops the start
    cur_tag = "R1";
    sel_dram = 1; set_in(1, 0, mk_cfg(1, 1, 1, 4, 3), 1); step();
    set_in(0, 0, cfg_word, 1); step();
    sel_dram = 0; sel_hs = 0; set_in(1, 0, cfg_word, 1); step();
    sel_hs = 1; set_in(0, 0, cfg_word, 1); step();
    // R1: legal start in handshake mode
    set_in(1, 0, mk_cfg(1, 1, 2, 5, 4), 1); step();
    chk("R1", "busy_after_start", busy, 1);
    idle_n(8);

    // R2: each illegal form
    cur_tag = "R2";
    set_in(1, 0, mk_cfg(0, 1, 1, 4, 2), 1); step();
    chk("R2", "err_smp00", cfg_err, 1);
    set_in(0, 0, cfg_word, 1); step();
    set_in(1, 1, mk_cfg(2, 0, 1, 4, 2), 1); step();
    chk("R2", "err_asr00", cfg_err, 1);
    set_in(0, 0, cfg_word, 1); step();
    set_in(1, 0, mk_cfg(1, 1, 1, 6, 7), 1); step();
    chk("R2", "err_end_lt_neg", cfg_err, 1);
    set_in(0, 0, cfg_word, 1); step();
    chk("R2", "err_one_clock", cfg_err, 0);

    // R6: long stall at sample count 2
    cur_tag = "R6";
    set_in(1, 1, mk_cfg(2, 1, 3, 10, 6), 1); step();
    set_in(0, 1, cfg_word, 1); step(); step();
    for (int i = 0; i < 8; i++) begin set_in(0, 1, cfg_word, 0); step(); end
    chk("R6", "wr_held_in_stall", wr_en, 1);
    idle_n(12);

    // R7: zero end time and equal end/negate
    cur_tag = "R7";
    set_in(1, 0, mk_cfg(3, 1, 0, 0, 0), 0); step();
    set_in(0, 0, cfg_word, 0); step();
    chk("R7", "done_end0", done, 1);
    idle_n(2);
    set_in(1, 0, mk_cfg(1, 2, 1, 5, 5), 1); step();
    idle_n(8);

    // R8 and R9: live inputs change and start repeats during a cycle
    cur_tag = "R8";
    set_in(1, 0, mk_cfg(1, 1, 2, 9, 7), 1); step();
    for (int i = 0; i < 6; i++) begin
      cur_tag = (i % 2 == 0) ? "R8" : "R9";
      set_in(1, 1, mk_cfg(1, 3, 0, 2, 1), 1); step();
    end
    idle_n(6);

    // random traffic
    cur_tag = "R3";
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [15:0] c;
      c = 16'($urandom);
      if ($urandom % 4 != 0) begin
        c[1:0] = 2'(1 + $urandom % 3);
        c[3:2] = 2'(1 + $urandom % 3);
        if (c[10:6] < c[15:11]) c = {c[10:6], c[15:11], c[5:0]};
      end
      sel_dram = ($urandom % 16 == 0);
      sel_hs   = ($urandom % 16 != 0);
      set_in(($urandom % 4 == 0), 1'($urandom), c, ($urandom % 3 != 0));
      step();
    end
    sel_dram = 0; sel_hs = 1;
    idle_n(40);
    summary();
    $finish;
  end
endmodule